// File: doc/BRIEF.md
# Virtqueue Transmit Buffer Reader

This block drains a split-ring virtqueue that a driver fills with outgoing data. A consumer asks for more bytes by toggling a single phase input. The block then works through the queue structures in memory over a one-word DMA port: the avail index, the avail ring, the descriptor table and the buffers. It hands back up to four bytes per request, together with a byte count, and raises `ready` once the word is valid for the current phase.

Descriptor chains are followed through their next links, and zero-length descriptors are skipped. When a chain is exhausted, the block returns it on the used ring as the head index and the total byte count, then advances the used index. If the consumer asks for data while the ring holds nothing new, the block parks until the driver pulses `kick`, then looks at the avail index again. Buffers may start at any byte address. Every memory access is a whole aligned 32-bit word.

Top module: `vq_tx_reader`

## Requirements
- R1: After reset, `ready` is 1 and `data_len` is 0, and `mem_valid` stays low until `phase` first differs from its reset value.
- R2: A request made while no descriptor is in progress starts with a read of the word at `avail_base`, whose bits 31:16 hold the driver's avail index. Buffers are new while that index differs from the block's own 16-bit count of consumed entries.
- R3: If the avail index shows nothing new, the block issues no memory access until `kick` is high, and then reads the avail index word again.
- R4: A ring entry is read at `avail_base + 4 + 2*slot`, aligned down to 4. Address bit 1 selects the half: bits 31:16 when it is 1, bits 15:0 when it is 0. The slot counts from 0 and wraps to 0 after `queue_size - 1`.
- R5: Descriptor `d` is read as three words: the buffer address at `desc_base + 16*d`, the length at `+8`, and the flags/next word at `+12`. In that word, bit 0 means "chained" and bits 31:16 give the next index.
- R6: Each delivery reads the aligned word that holds the current buffer byte. It returns `n = min(4 - addr%4, remaining)` bytes, the first byte in bits 7:0 and all bytes above `n` zero, sets `data_len = n`, and raises `ready`.
- R7: A chained descriptor continues with the next descriptor on the following request. A descriptor of length 0 produces no delivery.
- R8: After the last byte of an unchained descriptor, the block makes three full-strobe writes. It writes the head index at `used_base + 4 + 8*uslot`, then the chain's total length at the next word, then `{used_idx+1, 16'h0000}` at `used_base`. `uslot` wraps like the avail slot.
- R9: Every access uses a 4-byte-aligned address. Reads carry strobe 0 and writes strobe 4'hF. Address, data and strobe hold while `mem_valid` is high and `mem_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| queue_size | input | 16 | Number of ring slots |
| desc_base | input | AW | Descriptor table base address |
| avail_base | input | AW | Driver (avail) area base address |
| used_base | input | AW | Device (used) area base address |
| kick | input | 1 | Driver notification that new buffers were posted |
| phase | input | 1 | Consumer request toggle |
| data | output | 32 | Delivered bytes, first byte in bits 7:0 |
| data_len | output | 3 | Number of valid bytes in `data` (1 to 4) |
| ready | output | 1 | High when `data` answers the current phase |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request, read data valid this cycle |
| mem_wstrb | output | 4 | Byte write strobe, 0 for reads |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |

## Verification
The bench posts a request against an empty ring. A design that reads the wrong half of the avail index word, or that polls memory instead of parking, shows up as extra accesses before `kick`. Buffers start at byte offsets 1 and 3, and one chain carries a zero-length link. A design that shifts or masks wrongly, or that emits an empty delivery, breaks the scoreboard's byte-exact comparison. With a queue of three slots the avail and used slots wrap, so a design that forgets the wrap fetches the wrong descriptor or writes the used element to the wrong place. The full access trace of one buffer pins the order of reads and write-backs.

// File: rtl/vq_tx_reader.sv
module vq_tx_reader #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   queue_size,
  input  logic [AW-1:0] desc_base,
  input  logic [AW-1:0] avail_base,
  input  logic [AW-1:0] used_base,
  input  logic          kick,
  input  logic          phase,
  output logic [31:0]   data,
  output logic [2:0]    data_len,
  output logic          ready,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [3:0]    mem_wstrb,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  typedef enum logic [3:0] {
    S_IDLE, S_AIDX, S_KICK, S_RING, S_DADDR, S_DLEN, S_DFLAGS, S_BUF, S_UID, S_ULEN, S_UIDX
  } st_t;

  st_t          state;
  logic         ack, more;
  logic [15:0]  last_avail, aslot, used_idx, uslot, head, cur, nxt;
  logic [AW-1:0] baddr;
  logic [31:0]  remain, total;

  function automatic logic [15:0] step(input logic [15:0] s);
    return (s == queue_size - 16'd1) ? 16'd0 : s + 16'd1;
  endfunction

  logic [2:0]    room, n;
  logic [31:0]   mask;
  logic [AW-1:0] ring_addr, desc_addr, uelem;
  logic [15:0]   ring_ent;
  logic          fire, wr;

  assign room      = 3'd4 - {1'b0, baddr[1:0]};
  assign n         = (remain < 32'(room)) ? remain[2:0] : room;
  assign mask      = (n == 3'd4) ? 32'hFFFF_FFFF : ((32'd1 << {n[1:0], 3'b000}) - 32'd1);
  assign ring_addr = avail_base + AW'(4) + AW'({aslot, 1'b0});
  assign desc_addr = desc_base + AW'({cur, 4'b0000});
  assign uelem     = used_base + AW'(4) + AW'({uslot, 3'b000});
  assign ring_ent  = ring_addr[1] ? mem_rdata[31:16] : mem_rdata[15:0];
  assign ready     = (phase == ack);
  assign mem_valid = (state != S_IDLE) && (state != S_KICK);
  assign wr        = (state == S_UID) || (state == S_ULEN) || (state == S_UIDX);
  assign mem_wstrb = wr ? 4'hF : 4'h0;
  assign fire      = mem_valid && mem_ready;

  always_comb begin
    case (state)
      S_AIDX:   mem_addr = avail_base;
      S_RING:   mem_addr = {ring_addr[AW-1:2], 2'b00};
      S_DADDR:  mem_addr = desc_addr;
      S_DLEN:   mem_addr = desc_addr + AW'(8);
      S_DFLAGS: mem_addr = desc_addr + AW'(12);
      S_BUF:    mem_addr = {baddr[AW-1:2], 2'b00};
      S_UID:    mem_addr = uelem;
      S_ULEN:   mem_addr = uelem + AW'(4);
      S_UIDX:   mem_addr = used_base;
      default:  mem_addr = '0;
    endcase
    case (state)
      S_UID:   mem_wdata = {16'h0000, head};
      S_ULEN:  mem_wdata = total;
      S_UIDX:  mem_wdata = {used_idx + 16'd1, 16'h0000};
      default: mem_wdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; ack <= 1'b0; more <= 1'b0;
      last_avail <= '0; aslot <= '0; used_idx <= '0; uslot <= '0;
      head <= '0; cur <= '0; nxt <= '0; baddr <= '0; remain <= '0; total <= '0;
      data <= '0; data_len <= '0;
    end else begin
      case (state)
        S_IDLE: if (phase != ack) begin
          if (remain != 0)  state <= S_BUF;
          else if (more) begin cur <= nxt; state <= S_DADDR; end
          else              state <= S_AIDX;
        end
        S_AIDX: if (fire) state <= (mem_rdata[31:16] != last_avail) ? S_RING : S_KICK;
        S_KICK: if (kick) state <= S_AIDX;
        S_RING: if (fire) begin
          head <= ring_ent; cur <= ring_ent; total <= '0;
          last_avail <= last_avail + 16'd1; aslot <= step(aslot);
          state <= S_DADDR;
        end
        S_DADDR: if (fire) begin baddr <= mem_rdata[AW-1:0]; state <= S_DLEN; end
        S_DLEN:  if (fire) begin remain <= mem_rdata; state <= S_DFLAGS; end
        S_DFLAGS: if (fire) begin
          more <= mem_rdata[0]; nxt <= mem_rdata[31:16];
          if (remain != 0)      state <= S_BUF;
          else if (mem_rdata[0]) begin cur <= mem_rdata[31:16]; state <= S_DADDR; end
          else                  state <= S_UID;
        end
        S_BUF: if (fire) begin
          data     <= (mem_rdata >> {baddr[1:0], 3'b000}) & mask;
          data_len <= n;
          ack      <= ~ack;
          baddr    <= baddr + AW'(n);
          remain   <= remain - 32'(n);
          total    <= total + 32'(n);
          state    <= (remain == 32'(n) && !more) ? S_UID : S_IDLE;
        end
        S_UID:  if (fire) state <= S_ULEN;
        S_ULEN: if (fire) state <= S_UIDX;
        S_UIDX: if (fire) begin
          used_idx <= used_idx + 16'd1; uslot <= step(uslot); state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wstrb) && $stable(mem_wdata));
  a_r6_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (data_len != 3'd0) && (data_len <= 3'd4));
  a_r1_drop_on_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> phase != $past(phase));
  a_r3_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_KICK) && !kick |=> !mem_valid);
  a_r8_used_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(used_idx) |-> used_idx == $past(used_idx) + 16'd1);
endmodule

// File: tb/tb_vq_tx_reader.sv
module tb_vq_tx_reader;
  logic clk = 0, rst_n = 0, kick = 0, phase = 0, mem_ready;
  logic [31:0] data, mem_wdata, mem_rdata, mem_addr;
  logic [2:0] data_len;
  logic ready, mem_valid;
  logic [3:0] mem_wstrb;
  logic [15:0] queue_size = 16'd3;
  logic [31:0] desc_base = 32'h100, avail_base = 32'h200, used_base = 32'h300;

  always #5 clk = ~clk;

  vq_tx_reader #(.AW(32)) dut (
    .clk(clk), .rst_n(rst_n), .queue_size(queue_size), .desc_base(desc_base),
    .avail_base(avail_base), .used_base(used_base), .kick(kick), .phase(phase),
    .data(data), .data_len(data_len), .ready(ready), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_wstrb(mem_wstrb), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [31:0] mem [0:1023];
  logic [15:0] lfsr = 16'hACE1;
  int nchk = 0, nfail = 0, cyc = 0;
  int acc_a[$]; logic [3:0] acc_s[$]; logic [31:0] acc_d[$];
  logic [31:0] exp_d[$]; logic [2:0] exp_l[$];
  logic ready_q = 1'b1;
  bit done = 0;

  assign mem_ready = mem_valid && (lfsr[1:0] != 2'b00);
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (mem_valid && mem_ready) begin
      acc_a.push_back(int'(mem_addr)); acc_s.push_back(mem_wstrb); acc_d.push_back(mem_wdata);
      for (int b = 0; b < 4; b++)
        if (mem_wstrb[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  // monitor: scoreboard compare on each rising ready (R6)
  always @(negedge clk) begin
    if (rst_n && ready && !ready_q) begin
      if (exp_d.size() == 0) check(0, "R6 unexpected delivery", data, 32'h0);
      else begin
        logic [31:0] ed; logic [2:0] el;
        ed = exp_d.pop_front(); el = exp_l.pop_front();
        check(data == ed, "R6 data", data, ed);
        check(data_len == el, "R6 data_len", 32'(data_len), 32'(el));
      end
    end
    ready_q <= ready;
  end

  function automatic logic [7:0] pat(input int a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic fill_buf(input int a, input int len);
    for (int i = 0; i < len; i++) mem[(a + i) >> 2][8*((a + i) % 4) +: 8] = pat(a + i);
  endtask

  // driver side: expected chunks per R6
  task automatic push_buf(input int a, input int len);
    int p, rem;
    p = a; rem = len;
    while (rem > 0) begin
      int k; logic [31:0] w;
      k = 4 - (p % 4); if (rem < k) k = rem;
      w = 0;
      for (int i = 0; i < k; i++) w[8*i +: 8] = pat(p + i);
      exp_d.push_back(w); exp_l.push_back(3'(k));
      p += k; rem -= k;
    end
  endtask

  task automatic set_desc(input int d, input int a, input int len, input bit chain, input int nx);
    mem[(32'h100 + 16*d) >> 2]      = a;
    mem[(32'h100 + 16*d + 4) >> 2]  = 0;
    mem[(32'h100 + 16*d + 8) >> 2]  = len;
    mem[(32'h100 + 16*d + 12) >> 2] = {16'(nx), 15'h0, chain};
  endtask

  task automatic toggle();
    @(negedge clk); phase = ~phase;
  endtask

  task automatic wait_ready(input string req);
    int t = 0;
    @(negedge clk);
    while (!ready && t < 1000) begin @(negedge clk); t++; end
    check(ready, req, 32'(ready), 32'd1);
  endtask

  task automatic request(input string req);
    toggle(); wait_ready(req);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    mem[32'h200 >> 2] = {16'd0, 16'h0001};     // avail idx 0, flags nonzero
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset state and silence
    check(ready == 1'b1, "R1 ready after reset", 32'(ready), 32'd1);
    check(data_len == 3'd0, "R1 data_len after reset", 32'(data_len), 32'd0);
    repeat (20) @(negedge clk);
    check(acc_a.size() == 0, "R1 no access before phase", acc_a.size(), 0);

    // R2/R3: empty ring parks until kick
    toggle();
    repeat (40) @(negedge clk);
    check(ready == 1'b0, "R3 ready low while empty", 32'(ready), 32'd0);
    check(acc_a.size() == 1, "R3 single access while parked", acc_a.size(), 1);
    check(acc_a.size() > 0 && acc_a[0] == 32'h200, "R2 first read at avail_base",
          acc_a.size() > 0 ? acc_a[0] : -1, 32'h200);

    set_desc(0, 32'h400, 6, 0, 0);
    fill_buf(32'h400, 8);
    mem[32'h204 >> 2] = {16'h0000, 16'd0};
    mem[32'h200 >> 2] = {16'd1, 16'h0001};
    push_buf(32'h400, 6);
    @(negedge clk); kick = 1; @(negedge clk); kick = 0;
    wait_ready("R3 delivery after kick");
    request("R6 second chunk");
    repeat (60) @(negedge clk);
    begin
      int ea[11] = '{32'h200, 32'h200, 32'h204, 32'h100, 32'h108, 32'h10C,
                     32'h400, 32'h404, 32'h304, 32'h308, 32'h300};
      check(acc_a.size() == 11, "R9 access count buffer 0", acc_a.size(), 11);
      for (int i = 0; i < 11 && i < acc_a.size(); i++) begin
        check(acc_a[i] == ea[i], "R5 R8 access address order", acc_a[i], ea[i]);
        check(acc_s[i] == ((i >= 8) ? 4'hF : 4'h0), "R9 strobe", 32'(acc_s[i]), (i >= 8) ? 32'hF : 32'h0);
      end
    end
    check(mem[32'h304 >> 2] == 0, "R8 used id slot0", mem[32'h304 >> 2], 0);
    check(mem[32'h308 >> 2] == 6, "R8 used len slot0", mem[32'h308 >> 2], 6);
    check(mem[32'h300 >> 2] == 32'h0001_0000, "R8 used idx 1", mem[32'h300 >> 2], 32'h0001_0000);

    // R4/R7: slot 1 (upper half), unaligned chain with zero-length link
    set_desc(1, 32'h503, 2, 1, 2);
    set_desc(2, 32'h600, 0, 1, 3);
    set_desc(3, 32'h701, 5, 0, 0);
    fill_buf(32'h500, 8); fill_buf(32'h600, 8); fill_buf(32'h700, 12);
    mem[32'h204 >> 2] = {16'd1, 16'd0};
    mem[32'h200 >> 2] = {16'd2, 16'h0001};
    push_buf(32'h503, 2); push_buf(32'h701, 5);
    for (int i = 0; i < 4; i++) request("R7 chained delivery");
    repeat (60) @(negedge clk);
    check(exp_d.size() == 0, "R7 all chunks delivered", exp_d.size(), 0);
    check(mem[32'h30C >> 2] == 1, "R8 used id slot1", mem[32'h30C >> 2], 1);
    check(mem[32'h310 >> 2] == 7, "R8 used len chain total", mem[32'h310 >> 2], 7);
    check(mem[32'h300 >> 2] == 32'h0002_0000, "R8 used idx 2", mem[32'h300 >> 2], 32'h0002_0000);

    // R4: slot wrap with queue_size 3
    set_desc(4, 32'h800, 4, 0, 0);
    set_desc(5, 32'h900, 3, 0, 0);
    fill_buf(32'h800, 4); fill_buf(32'h900, 4);
    mem[32'h208 >> 2] = {16'hFFFF, 16'd4};
    mem[32'h204 >> 2] = {16'd1, 16'd5};
    mem[32'h200 >> 2] = {16'd4, 16'h0001};
    push_buf(32'h800, 4); push_buf(32'h900, 3);
    request("R4 slot 2 delivery");
    request("R4 wrapped slot 0 delivery");
    repeat (60) @(negedge clk);
    check(exp_d.size() == 0, "R4 wrap chunks delivered", exp_d.size(), 0);
    check(mem[32'h314 >> 2] == 4, "R8 used id slot2", mem[32'h314 >> 2], 4);
    check(mem[32'h318 >> 2] == 4, "R8 used len slot2", mem[32'h318 >> 2], 4);
    check(mem[32'h304 >> 2] == 5, "R8 used id wrapped slot0", mem[32'h304 >> 2], 5);
    check(mem[32'h308 >> 2] == 3, "R8 used len wrapped slot0", mem[32'h308 >> 2], 3);
    check(mem[32'h300 >> 2] == 32'h0004_0000, "R8 used idx 4", mem[32'h300 >> 2], 32'h0004_0000);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule